// File: doc/BRIEF.md
# I2C Register-Write Slave

This block is a bus slave for the two-wire serial protocol. It answers one fixed 7-bit device address, `1000011`. After that address with a write direction bit, it takes one sub-address byte as a register pointer. It then takes any number of data bytes and turns each one into a single-cycle write on a parallel register port. After every write the pointer advances by one, so a transfer can fill a run of registers from any start address. A transfer with a single data byte is the simplest case.

A fast system clock oversamples both bus lines. Each line passes through a two-flop synchronizer. A third flop holds the previous sample, and comparing it with the current one gives rising and falling edges. START and STOP are SDA edges seen while SCL is high. Data bits are taken on SCL rising edges, most significant bit first. The slave never drives SDA high: its only bus output is an enable that pulls SDA low for the acknowledge bit.

The controller is an eight-state machine:
- `ST_IDLE`: waits for START.
- `ST_DEV`: collects the device byte.
- `ST_DEV_ACK`: acknowledges the device byte.
- `ST_SUB`: collects the sub-address byte.
- `ST_SUB_ACK`: acknowledges the sub-address byte.
- `ST_DATA`: collects a data byte.
- `ST_DATA_ACK`: acknowledges a data byte.
- `ST_IGNORE`: stays silent after a rejected device byte.

The transitions are:
- START in any state leads to `ST_DEV`.
- STOP in any state leads to `ST_IDLE`.
- From `ST_DEV`, the SCL falling edge after the 8th bit leads to `ST_DEV_ACK` on a match with a write bit, and to `ST_IGNORE` otherwise.
- `ST_SUB` leads to `ST_SUB_ACK`, and `ST_DATA` leads to `ST_DATA_ACK`, on that same falling edge.
- At the SCL falling edge that ends the 9th pulse, `ST_DEV_ACK` leads to `ST_SUB`, `ST_SUB_ACK` leads to `ST_DATA`, and `ST_DATA_ACK` leads back to `ST_DATA`.

Top module: `i2c_regwr_slave`

## Requirements
- R1: A falling SDA edge while SCL is high is a START. From any state, including in the middle of a transfer, it restarts reception of the device byte.
- R2: A rising SDA edge while SCL is high is a STOP. From any state it returns the slave to idle with the pull-down released. Bytes clocked after a STOP without a new START get no acknowledge and cause no write.
- R3: Bits are taken on SCL rising edges and assembled most significant bit first.
- R4: A device byte of `1000011` followed by a write bit of 0 (byte value 0x86) is acknowledged. The pull-down is on from the SCL falling edge after the 8th bit until the SCL falling edge after the 9th bit.
- R5: A device byte with any other address, or with the direction bit set to 1 (read), gets no acknowledge. The slave then ignores the bus until the next START: no acknowledge and no write.
- R6: The byte after an accepted device byte is acknowledged and loaded as the register pointer.
- R7: Each later byte is acknowledged and produces exactly one `wr_en_o` pulse, one clock wide. On that pulse, `wr_addr_o` equals the pointer and `wr_data_o` equals the byte.
- R8: The pointer increments after every data byte and wraps modulo 2^ADDR_W, until a STOP or START.
- R9: After reset, `sda_pd_o` and `wr_en_o` are low and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pd_o | output | 1 | When high, the open-drain driver pulls SDA low |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | ADDR_W | Register address for the write |
| wr_data_o | output | 8 | Register data for the write |

## Verification
The assertions assume a master that follows the protocol:
- SDA changes only while SCL is low, except for START and STOP.
- No START or STOP is attempted while the slave holds SDA low.
- Each SCL level lasts several system clocks, far longer than the synchronizer delay.

Under these assumptions, the acknowledge pull-down never changes during an SCL high phase. The stimulus models the wired-AND bus by combining the master's drive with the pull-down. It holds each quarter bit for ten clocks and moves SDA only in the middle of SCL low phases.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev;
    assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o,
    output logic         full_o
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            data_o <= '0;
        end else if (clr_i) begin
            cnt <= '0;
        end else if (shift_i && (cnt != CW'(W))) begin
            data_o <= {data_o[W-2:0], bit_i};
            cnt    <= cnt + 1'b1;
        end
    end

    assign full_o = (cnt == CW'(W));
endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave
    import i2c_regwr_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'b1000011,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pd_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam int unsigned N_LINES = 2;
    localparam int unsigned L_SCL   = 0;
    localparam int unsigned L_SDA   = 1;

    logic [N_LINES-1:0] raw_line;
    logic [N_LINES-1:0] lvl;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] fall;

    assign raw_line = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_sync
            i2c_line_sync #(
                .STAGES (SYNC_STAGES),
                .RST_VAL(1'b1)
            ) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_i (raw_line[g]),
                .level_o(lvl[g]),
                .rise_o (rise[g]),
                .fall_o (fall[g])
            );
        end
    endgenerate

    logic scl_lvl, scl_rise, scl_fall;
    logic start_det, stop_det;

    assign scl_lvl   = lvl[L_SCL];
    assign scl_rise  = rise[L_SCL];
    assign scl_fall  = fall[L_SCL];
    assign start_det = scl_lvl & fall[L_SDA];
    assign stop_det  = scl_lvl & rise[L_SDA];

    slv_state_e        state, nxt;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_full;
    logic              in_ack, in_rx;
    logic              shift_en, shift_clr;
    logic [ADDR_W-1:0] ptr;

    assign in_ack = (state == ST_DEV_ACK) || (state == ST_SUB_ACK) || (state == ST_DATA_ACK);
    assign in_rx  = (state == ST_DEV) || (state == ST_SUB) || (state == ST_DATA);

    assign shift_en  = scl_rise & in_rx;
    assign shift_clr = start_det | stop_det | (scl_fall & in_ack);

    i2c_rx_shift #(.W(BYTE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (shift_clr),
        .shift_i(shift_en),
        .bit_i  (lvl[L_SDA]),
        .data_o (rx_byte),
        .full_o (rx_full)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: nxt = state;
                ST_DEV: if (scl_fall && rx_full)
                            nxt = ((rx_byte[7:1] == DEV_ADDR) && !rx_byte[0]) ? ST_DEV_ACK : ST_IGNORE;
                ST_SUB:  if (scl_fall && rx_full) nxt = ST_SUB_ACK;
                ST_DATA: if (scl_fall && rx_full) nxt = ST_DATA_ACK;
                ST_DEV_ACK:  if (scl_fall) nxt = ST_SUB;
                ST_SUB_ACK:  if (scl_fall) nxt = ST_DATA;
                ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs: pointer and write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (state == ST_SUB && nxt == ST_SUB_ACK) begin
                ptr <= ADDR_W'(rx_byte);
            end
            if (state == ST_DATA && nxt == ST_DATA_ACK) begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr;
                wr_data_o <= rx_byte;
                ptr       <= ptr + 1'b1;
            end
        end
    end

    assign sda_pd_o = in_ack;
endmodule

// File: rtl/i2c_regwr_slave_chk.sv
module i2c_regwr_slave_chk
    import i2c_regwr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       start_det,
    input logic       stop_det,
    input slv_state_e state,
    input logic       sda_pd_o,
    input logic       wr_en_o
);
    p_start_dev_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV));

    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_pd_o));

    p_pd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pd_o));

    p_ignore_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_pd_o && !wr_en_o));

    p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    p_wr_in_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (state == ST_DATA_ACK));
endmodule

bind i2c_regwr_slave i2c_regwr_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .start_det(start_det),
    .stop_det (stop_det),
    .state    (state),
    .sda_pd_o (sda_pd_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/tb_i2c_regwr_slave.sv
module tb_i2c_regwr_slave;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pd_o, wr_en_o;
    logic [7:0] wr_addr_o, wr_data_o;

    int checks = 0;
    int fails  = 0;

    typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
    wr_t exp_q[$];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pd_o;

    i2c_regwr_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pd_o(sda_pd_o), .wr_en_o(wr_en_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl = 1'b1;   wq(2*Q);
            scl = 1'b0;   wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        acked = ~sda_line;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    // full write transfer: device byte, sub-address, n data bytes
    task automatic wr_xfer(input logic [7:0] sub, input int n, input logic [7:0] dat [4],
                           input bit do_stop);
        logic ack;
        i2c_start();
        send_byte(8'h86, ack);
        chk("R4 device byte ack", ack, 1'b1);
        send_byte(sub, ack);
        chk("R6 sub-address ack", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{a: sub + 8'(i), d: dat[i]});
            send_byte(dat[i], ack);
            chk("R7 data ack", ack, 1'b1);
        end
        if (do_stop) i2c_stop();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_en_o) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R5 unexpected write actual=%0h:%0h expected=none",
                         wr_addr_o, wr_data_o);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk("R7 R8 write addr", {24'h0, wr_addr_o}, {24'h0, e.a});
                chk("R3 R7 write data", {24'h0, wr_data_o}, {24'h0, e.d});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d [4];
        wq(5);
        rst_n = 1'b1;
        wq(5);
        // R9 reset state
        chk("R9 pd after reset", sda_pd_o, 1'b0);
        chk("R9 strobe after reset", wr_en_o, 1'b0);
        scl = 1'b0; wq(Q);
        send_byte(8'h86, ack);
        chk("R9 no ack without START", ack, 1'b0);
        scl = 1'b1; wq(Q);

        // single byte write, MSB-first pattern (R3)
        d = '{8'hA5, 8'h00, 8'h00, 8'h00};
        wr_xfer(8'h10, 1, d, 1'b1);
        chk("R2 pd after STOP", sda_pd_o, 1'b0);
        scl = 1'b0; wq(Q);
        send_byte(8'h55, ack);
        chk("R2 byte after STOP ignored", ack, 1'b0);
        scl = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);

        // multibyte write with pointer wrap (R8), R3 bit-order patterns
        d = '{8'h01, 8'h80, 8'h3C, 8'h00};
        wr_xfer(8'hFE, 3, d, 1'b1);

        // address mismatch (R5)
        i2c_start();
        send_byte(8'h88, ack);
        chk("R5 wrong address no ack", ack, 1'b0);
        send_byte(8'h20, ack);
        chk("R5 ignored byte no ack", ack, 1'b0);
        send_byte(8'h99, ack);
        chk("R5 ignored data no ack", ack, 1'b0);
        i2c_stop();

        // read direction bit (R5)
        i2c_start();
        send_byte(8'h87, ack);
        chk("R5 read request no ack", ack, 1'b0);
        send_byte(8'h12, ack);
        chk("R5 after read no ack", ack, 1'b0);
        i2c_stop();

        // repeated START after sub-address restarts (R1)
        i2c_start();
        send_byte(8'h86, ack);
        chk("R1 first device ack", ack, 1'b1);
        send_byte(8'h30, ack);
        chk("R1 first sub ack", ack, 1'b1);
        d = '{8'h77, 8'hE1, 8'h00, 8'h00};
        wr_xfer(8'h50, 2, d, 1'b0);

        // repeated START after a mismatch recovers (R1, R5)
        i2c_start();
        send_byte(8'h42, ack);
        chk("R5 mismatch before restart", ack, 1'b0);
        d = '{8'hC3, 8'h00, 8'h00, 8'h00};
        wr_xfer(8'h07, 1, d, 1'b1);

        wq(20);
        chk("R7 all expected writes seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule